// File: doc/BRIEF.md
# LCD Pixel Unpacker with Gray-Level Palette

This block sits between a frame-buffer DMA engine and a monochrome LCD driver. It holds up to nine 32-bit frame-buffer words in a small FIFO and requests a refill early, while five or fewer words remain. This gives the DMA engine time to respond before the display runs dry. On each pixel-clock enable it takes the next pixel from the head word and emits a registered 4-bit gray code.

A word is split into 1-, 2- or 4-bit pixels, lowest bits first. Each pixel value selects one 4-bit entry of a 64-bit palette formed from two 32-bit configuration words. The pixel depth is captured only while the block is disabled. Disabling the block empties the FIFO and rewinds the pixel position. Two sticky flags report a pixel demanded from an empty FIFO and a word written into a full one.

Top module: `lcd_pix_unpack`

## Requirements
- R1: The FIFO holds 9 words. A write is accepted when `en` is high and the FIFO is not full. A write while full is dropped and sets the sticky `overflow` flag, which only reset clears.
- R2: `dma_req` is high exactly when `en` is high, the occupancy is 5 or fewer, and the FIFO is not full. It follows a write or a pop one cycle later.
- R3: `bpp_mode` encodes the depth as 2'b00 = 1 bit, 2'b01 = 2 bits, 2'b10 = 4 bits, and 2'b11 = 4 bits. It is captured only while `en` is low, so a change while enabled has no effect.
- R4: Pixel k of a word at depth b comes from bits [k*b+b-1 : k*b]. Pixel 0 is the least significant and is emitted first.
- R5: Pixel value v produces the gray code {pal_hi, pal_lo}[4v+3 : 4v].
- R6: A word yields 32, 16 or 8 pixels at 1, 2 or 4 bits. It is popped with its last pixel, and the next pixel comes from the following word.
- R7: `gray_valid` is high in the cycle after a cycle with `en` and `pix_tick` both high, and is low otherwise.
- R8: A tick with an empty FIFO gives gray code 0 with `gray_valid` high. It also sets the sticky `underrun` flag, which only reset clears.
- R9: While `en` is low the FIFO is emptied, the pixel position returns to 0, and writes are ignored.
- R10: After reset `gray_valid`, `gray`, `underrun`, `overflow` and `dma_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low flushes and allows a depth change |
| bpp_mode | input | 2 | Pixel depth select |
| pal_lo | input | 32 | Palette entries 0 to 7 |
| pal_hi | input | 32 | Palette entries 8 to 15 |
| wr_valid | input | 1 | Frame-buffer word write strobe |
| wr_data | input | 32 | Frame-buffer word |
| pix_tick | input | 1 | Pixel-clock enable, one pixel per high cycle |
| gray | output | 4 | Gray-level code |
| gray_valid | output | 1 | Gray code strobe |
| dma_req | output | 1 | Refill request |
| underrun | output | 1 | Sticky empty-on-demand flag |
| overflow | output | 1 | Sticky write-while-full flag |

## Verification
The gray code and its strobe are due one clock after the tick cycle. `dma_req` and `overflow` settle one clock after the write or the last-pixel pop that changes the occupancy. The bench drives on the falling edge. A monitor compares every strobed code on the following falling edge against a queue filled by the driver at tick time, so each result is matched exactly one clock after its cause. Level checks on `dma_req` and the flags are made a short delay after a falling edge, once the posedge update has settled.

// File: rtl/lcd_unpack_pkg.sv
package lcd_unpack_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        BPP_1   = 2'b00,
        BPP_2   = 2'b01,
        BPP_4   = 2'b10,
        BPP_4_X = 2'b11
    } bpp_e;

    typedef struct packed {
        logic              req;
        logic              hit;
        logic [CODE_W-1:0] val;
    } pix_t;

    function automatic logic [5:0] px_per_word(bpp_e m);
        case (m)
            BPP_1:   return 6'd32;
            BPP_2:   return 6'd16;
            default: return 6'd8;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] px_extract(logic [WORD_W-1:0] w,
                                                     logic [4:0] idx,
                                                     bpp_e m);
        logic [WORD_W-1:0] sh;
        case (m)
            BPP_1: begin
                sh = w >> idx;
                return {3'b000, sh[0]};
            end
            BPP_2: begin
                sh = w >> {idx, 1'b0};
                return {2'b00, sh[1:0]};
            end
            default: begin
                sh = w >> {idx, 2'b00};
                return sh[3:0];
            end
        endcase
    endfunction

endpackage

// File: rtl/lcd_word_fifo.sv
module lcd_word_fifo #(
    parameter int DEPTH     = 9,
    parameter int W         = 32,
    parameter int WATERMARK = 5,
    localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          dma_req,
    output logic          overflow
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] WM_C    = CW'(WATERMARK);
    localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == DEPTH_C);
    assign head    = mem[rd_ptr];
    assign do_wr   = active && wr_en && !full;
    assign do_rd   = active && rd_en && !empty;
    assign dma_req = active && !full && (count <= WM_C);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          overflow <= 1'b0;
        else if (active && wr_en && full) overflow <= 1'b1;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);
    assert_full_drop_R1: assert property (@(posedge clk) disable iff (rst)
        (active && full && wr_en && !rd_en) |=> (full && overflow));
    assert_overflow_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    assert_req_not_full_R2: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (!full && active));
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
        !active |=> empty);
endmodule

// File: rtl/lcd_pix_sel.sv
module lcd_pix_sel
    import lcd_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        bpp_in,
    input  logic              tick,
    input  logic [WORD_W-1:0] head,
    input  logic              empty,
    output logic              pop,
    output pix_t              pix,
    output logic              underrun
);
    bpp_e       cfg_bpp;
    logic [4:0] idx;
    logic [5:0] ppw;
    logic [4:0] last_idx;
    logic       take;

    assign ppw      = px_per_word(cfg_bpp);
    assign last_idx = 5'(ppw - 6'd1);
    assign take     = en && tick && !empty;
    assign pop      = take && (idx == last_idx);

    assign pix.req = en && tick;
    assign pix.hit = !empty;
    assign pix.val = px_extract(head, idx, cfg_bpp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_bpp <= BPP_1;
            idx     <= '0;
        end else if (!en) begin
            cfg_bpp <= bpp_e'(bpp_in);
            idx     <= '0;
        end else if (take) begin
            idx <= pop ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      underrun <= 1'b0;
        else if (en && tick && empty) underrun <= 1'b1;
    end

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        {1'b0, idx} < ppw);
    assert_pop_rewinds_R6: assert property (@(posedge clk) disable iff (rst)
        pop |=> (idx == '0));
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(cfg_bpp));
    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
    assert_disable_rewind_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (idx == '0));
endmodule

// File: rtl/lcd_gray_lut.sv
module lcd_gray_lut
    import lcd_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pix_t              pix,
    input  logic [WORD_W-1:0] pal_lo,
    input  logic [WORD_W-1:0] pal_hi,
    output logic [CODE_W-1:0] gray,
    output logic              gray_valid
);
    logic [2*WORD_W-1:0] pal_all;
    logic [CODE_W-1:0]   code_d;

    assign pal_all = {pal_hi, pal_lo};
    assign code_d  = pal_all[{pix.val, 2'b00} +: CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            gray       <= '0;
            gray_valid <= 1'b0;
        end else begin
            gray_valid <= pix.req;
            if (pix.req) gray <= pix.hit ? code_d : '0;
        end
    end

    assert_valid_after_req_R7: assert property (@(posedge clk) disable iff (rst)
        pix.req |=> gray_valid);
    assert_quiet_without_req_R7: assert property (@(posedge clk) disable iff (rst)
        !pix.req |=> !gray_valid);
    assert_miss_gives_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (pix.req && !pix.hit) |=> (gray == '0));
endmodule

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack
    import lcd_unpack_pkg::*;
#(
    parameter int FIFO_DEPTH = 9,
    parameter int REFILL_WM  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        bpp_mode,
    input  logic [WORD_W-1:0] pal_lo,
    input  logic [WORD_W-1:0] pal_hi,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pix_tick,
    output logic [CODE_W-1:0] gray,
    output logic              gray_valid,
    output logic              dma_req,
    output logic              underrun,
    output logic              overflow
);
    logic [WORD_W-1:0] head;
    logic              empty, full, pop;
    pix_t              pix;

    lcd_word_fifo #(
        .DEPTH(FIFO_DEPTH), .W(WORD_W), .WATERMARK(REFILL_WM)
    ) u_fifo (
        .clk(clk), .rst(rst), .active(en),
        .wr_en(wr_valid), .wr_data(wr_data), .rd_en(pop),
        .head(head), .empty(empty), .full(full),
        .dma_req(dma_req), .overflow(overflow)
    );

    lcd_pix_sel u_sel (
        .clk(clk), .rst(rst), .en(en), .bpp_in(bpp_mode),
        .tick(pix_tick), .head(head), .empty(empty),
        .pop(pop), .pix(pix), .underrun(underrun)
    );

    lcd_gray_lut u_lut (
        .clk(clk), .rst(rst), .pix(pix),
        .pal_lo(pal_lo), .pal_hi(pal_hi),
        .gray(gray), .gray_valid(gray_valid)
    );

    assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!gray_valid && !underrun && !overflow));
endmodule

// File: tb/tb_lcd_pix_unpack.sv
module tb_lcd_pix_unpack;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  bpp_mode = 2'b00;
    logic [31:0] pal_lo, pal_hi;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pix_tick = 1'b0;
    logic [3:0]  gray;
    logic        gray_valid, dma_req, underrun, overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] mq[$];
    int          midx = 0;
    int          mbits = 1;
    logic [3:0]  exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R4";

    always #2.5 clk = ~clk;

    lcd_pix_unpack dut (
        .clk(clk), .rst(rst), .en(en), .bpp_mode(bpp_mode),
        .pal_lo(pal_lo), .pal_hi(pal_hi),
        .wr_valid(wr_valid), .wr_data(wr_data), .pix_tick(pix_tick),
        .gray(gray), .gray_valid(gray_valid), .dma_req(dma_req),
        .underrun(underrun), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pal_code(int v);
        logic [63:0] p;
        p = {pal_hi, pal_lo};
        return 4'((p >> (4 * v)) & 64'hF);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && gray_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected strobe", 1, 0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(gray == e, t, gray, e);
            end
        end
    end

    task automatic set_en(input logic v);
        @(negedge clk);
        en = v;
        if (!v) begin
            mq.delete();
            midx = 0;
        end else begin
            mbits = (bpp_mode == 2'b00) ? 1 : (bpp_mode == 2'b01) ? 2 : 4;
        end
    endtask

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data = w;
        if (en && mq.size() < 9) mq.push_back(w);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic tick(input int gap);
        @(negedge clk);
        pix_tick = 1'b1;
        if (en) begin
            if (mq.size() == 0) begin
                exp_q.push_back(4'd0);
                tag_q.push_back("R8 empty tick");
            end else begin
                int v;
                v = int'((mq[0] >> (midx * mbits)) & ((32'd1 << mbits) - 1));
                exp_q.push_back(pal_code(v));
                tag_q.push_back(cur_tag);
                midx++;
                if (midx == 32 / mbits) begin
                    midx = 0;
                    void'(mq.pop_front());
                end
            end
        end
        @(negedge clk);
        pix_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(i % 3);
    endtask

    task automatic settle;
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 120000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int n = 0; n < 8; n++) begin
            pal_lo[4*n +: 4] = 4'((n * 7 + 3) & 15);
            pal_hi[4*n +: 4] = 4'(((n + 8) * 7 + 3) & 15);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();
        chk(!gray_valid && gray == 0, "R10 gray idle", int'(gray_valid), 0);
        chk(!dma_req && !underrun && !overflow, "R10 flags low",
            int'({dma_req, underrun, overflow}), 0);

        // 4 bpp, fill, watermark, overflow
        bpp_mode = 2'b10;
        settle();
        set_en(1'b1);
        settle();
        chk(dma_req, "R2 request when empty", dma_req, 1);
        for (int i = 0; i < 5; i++) wr_word(32'h8ACE_0000 + 32'(i * 32'h1357_9BDF));
        #1;
        chk(dma_req, "R2 request at five", dma_req, 1);
        wr_word(32'h0123_4567);
        #1;
        chk(!dma_req, "R2 no request at six", dma_req, 0);
        wr_word(32'hFEDC_BA98);
        wr_word(32'h5A5A_C3C3);
        wr_word(32'h0F1E_2D3C);
        #1;
        chk(!overflow, "R1 no overflow at nine", overflow, 0);
        wr_word(32'hDEAD_BEEF);
        #1;
        chk(overflow, "R1 overflow on full write", overflow, 1);
        chk(!dma_req, "R2 no request when full", dma_req, 0);
        cur_tag = "R4 R5 R6 4bpp";
        ticks(24);
        settle();
        chk(!dma_req, "R6 six words left after 24 pixels", dma_req, 0);
        ticks(8);
        settle();
        chk(dma_req, "R6 pop at 32nd pixel gives five", dma_req, 1);
        ticks(40);
        settle();
        chk(!underrun, "R8 no underrun while data", underrun, 0);
        tick(0);
        settle();
        chk(underrun, "R8 underrun set", underrun, 1);
        chk(overflow, "R1 overflow sticky", overflow, 1);

        // 2 bpp
        set_en(1'b0);
        bpp_mode = 2'b01;
        settle();
        set_en(1'b1);
        wr_word(32'hE4E4_1B1B);
        wr_word(32'h9C36_A5F0);
        cur_tag = "R4 R5 R6 2bpp";
        ticks(32);

        // 1 bpp, change of depth while enabled ignored
        set_en(1'b0);
        bpp_mode = 2'b00;
        settle();
        set_en(1'b1);
        wr_word(32'hB38F_0D61);
        @(negedge clk);
        bpp_mode = 2'b10;
        cur_tag = "R3 R4 R5 1bpp held";
        ticks(32);
        settle();
        chk(dma_req, "R6 word fully consumed", dma_req, 1);

        // encoding 11 acts as 4 bpp
        set_en(1'b0);
        bpp_mode = 2'b11;
        settle();
        set_en(1'b1);
        wr_word(32'h7654_3210);
        cur_tag = "R3 code 11 is 4bpp";
        ticks(8);

        // flush on disable, writes ignored while disabled
        bpp_mode = 2'b10;
        wr_word(32'h1111_2222);
        wr_word(32'h3333_4444);
        cur_tag = "R9 before flush";
        ticks(3);
        set_en(1'b0);
        wr_word(32'hCAFE_F00D);
        set_en(1'b1);
        settle();
        chk(dma_req, "R9 occupancy zero after flush", dma_req, 1);
        tick(0);
        wr_word(32'h8765_4321);
        cur_tag = "R9 index rewound";
        ticks(2);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all strobes seen", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule